// File: doc/BRIEF.md
# Multi-domain bus clock-enable prescaler

This block runs entirely on one fast system clock and produces a set of single-cycle clock-enable strobes, one per derived domain. No divided clock is ever generated. Downstream logic stays on the system clock and advances only in cycles where its domain's strobe is high. The domains are a main bus, a fast and a slow peripheral bus, a timer domain for each peripheral bus, an ADC domain, a system-timer reference tick and a fixed half-rate storage-interface domain.

The domains form a tree. Every derived strobe counts strobes of its parent, so it can only fire in a cycle where the parent fires. After reset all domains start in phase. A new divisor code is picked up only when the affected counter wraps, so no period is ever cut short or stretched. A combinational flag compares the selected ratios against the configured system-clock frequency. It reports settings that would run the slow bus or the ADC domain above their limits.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low every strobe output is low. In the first cycle after `rst_n` rises, all eight strobes are high together.
- R2: `main_stb` fires once every Dm system cycles. For `main_sel` 0..7 Dm is 1. For `main_sel` 8..15 Dm is 2, 4, 8, 16, 64, 128, 256 and 512 respectively.
- R3: `fast_stb` and `slow_stb` fire once every Db main strobes, and each bus has its own code. For codes 0..3 Db is 1. For codes 4, 5, 6 and 7 Db is 2, 4, 8 and 16.
- R4: The timer strobe of a bus equals that bus's strobe when Db is 1. Otherwise it fires every Db/2 main strobes, and every bus strobe is also a timer strobe.
- R5: `adc_stb` fires once every Da fast-bus strobes, with Da = 2 × (`adc_sel` + 1), giving 2, 4, 6 or 8.
- R6: `tick_stb` fires once every 8 main strobes.
- R7: `store_stb` fires once every 2 main strobes.
- R8: Each strobe is high for one cycle per period, and a derived strobe is high only in cycles where its parent strobe is high.
- R9: A divisor code change takes effect only after the current period of that domain ends. The next strobe still comes at the old spacing, and the strobes after it follow the new spacing.
- R10: `over_limit` is high exactly when SYS_HZ > SLOW_MAX_HZ·Dm·Ds or SYS_HZ > ADC_MAX_HZ·Dm·Df·Da. With the defaults these limits are 72 MHz, 36 MHz and 14 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| main_sel | input | 4 | Main bus divisor code |
| fast_sel | input | 3 | Fast peripheral bus divisor code |
| slow_sel | input | 3 | Slow peripheral bus divisor code |
| adc_sel | input | 2 | ADC divisor code |
| main_stb | output | 1 | Main bus enable strobe |
| fast_stb | output | 1 | Fast peripheral bus enable strobe |
| fast_tmr_stb | output | 1 | Timer strobe of the fast bus |
| slow_stb | output | 1 | Slow peripheral bus enable strobe |
| slow_tmr_stb | output | 1 | Timer strobe of the slow bus |
| adc_stb | output | 1 | ADC domain strobe |
| tick_stb | output | 1 | System-timer reference strobe |
| store_stb | output | 1 | Storage-interface strobe |
| over_limit | output | 1 | Selected ratios exceed the slow-bus or ADC frequency limit |

## Verification
Every main code is run with the buses at /1, which separates the eight power-of-two main ratios and shows that codes 0..7 all mean /1. All 256 combinations of fast, slow and ADC codes are then run under a /1 main bus, plus a few mixed cases on a divided main bus. These show that the two buses decode independently, that the timer strobes switch between equal rate and double rate, and that the ADC divides by 6 correctly. Each of these runs starts from reset, so every strobe is expected exactly at multiples of its total ratio, and the rate flag is checked against the same products. One directed run changes a bus code in the middle of a period, to tell reload at the period boundary apart from an immediate switch.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int MAIN_SEL_W = 4;
  localparam int BUS_SEL_W  = 3;
  localparam int ADC_SEL_W  = 2;
  localparam int MAIN_CNT_W = 9;   // up to /512
  localparam int BUS_CNT_W  = 4;   // up to /16
  localparam int ADC_CNT_W  = 3;   // up to /8

  // main: top bit clear -> /1; else 2^(n+1), skipping /32
  function automatic int unsigned main_ratio(input logic [MAIN_SEL_W-1:0] code);
    int unsigned e;
    if (!code[3]) return 1;
    e = 32'(code[2:0]) + 1 + (code[2] ? 1 : 0);
    return 32'd1 << e;
  endfunction

  function automatic int unsigned bus_ratio(input logic [BUS_SEL_W-1:0] code);
    if (!code[2]) return 1;
    return 32'd1 << (32'(code[1:0]) + 1);
  endfunction

  function automatic int unsigned adc_ratio(input logic [ADC_SEL_W-1:0] code);
    return 2 * (32'(code) + 1);
  endfunction
endpackage

// File: rtl/sub_div.sv
module sub_div #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parent_stb,
  input  logic [CNT_W-1:0] div_m1,
  output logic             stb
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (parent_stb) begin
      if (cnt_q == '0) cnt_d = div_m1;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stb = parent_stb && (cnt_q == '0);

  // R9: the divisor seen at the wrap is what the next period counts
  assert_reload_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (cnt_q == $past(div_m1)));
endmodule

// File: rtl/bus_div.sv
module bus_div import strobe_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 parent_stb,
  input  logic [BUS_SEL_W-1:0] sel,
  output logic                 stb,
  output logic                 tmr_stb
);
  localparam int W = BUS_CNT_W;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] act_q, act_d;   // active ratio minus one
  logic [W-1:0] sel_m1;
  logic [W:0]   half;
  logic         wrap;

  assign sel_m1 = W'(bus_ratio(sel) - 1);
  assign wrap   = parent_stb && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (parent_stb) begin
      if (wrap) begin
        cnt_d = sel_m1;
        act_d = sel_m1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // midpoint of the running period; for a ratio of 1 it is 0 (same as wrap)
  assign half    = ({1'b0, act_q} + 1'b1) >> 1;
  assign stb     = wrap;
  assign tmr_stb = parent_stb && ((cnt_q == '0) || ({1'b0, cnt_q} == half));

  // R4: every bus strobe is also a timer strobe
  assert_bus_in_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> tmr_stb);
  // R9: the period length is latched only at the wrap
  assert_ratio_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(act_q));
endmodule

// File: rtl/rate_guard.sv
module rate_guard import strobe_pkg::*; #(
  parameter longint unsigned SYS_HZ      = 72_000_000,
  parameter longint unsigned SLOW_MAX_HZ = 36_000_000,
  parameter longint unsigned ADC_MAX_HZ  = 14_000_000
) (
  input  logic [MAIN_SEL_W-1:0] main_sel,
  input  logic [BUS_SEL_W-1:0]  fast_sel,
  input  logic [BUS_SEL_W-1:0]  slow_sel,
  input  logic [ADC_SEL_W-1:0]  adc_sel,
  output logic                  over_limit
);
  longint unsigned slow_cap, adc_cap;

  always_comb begin
    slow_cap = SLOW_MAX_HZ * 64'(main_ratio(main_sel)) * 64'(bus_ratio(slow_sel));
    adc_cap  = ADC_MAX_HZ * 64'(main_ratio(main_sel)) * 64'(bus_ratio(fast_sel))
               * 64'(adc_ratio(adc_sel));
    over_limit = (SYS_HZ > slow_cap) || (SYS_HZ > adc_cap);
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen import strobe_pkg::*; #(
  parameter longint unsigned SYS_HZ      = 72_000_000,
  parameter longint unsigned SLOW_MAX_HZ = 36_000_000,
  parameter longint unsigned ADC_MAX_HZ  = 14_000_000,
  parameter int              TICK_RATIO  = 8,
  parameter int              STORE_RATIO = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MAIN_SEL_W-1:0] main_sel,
  input  logic [BUS_SEL_W-1:0]  fast_sel,
  input  logic [BUS_SEL_W-1:0]  slow_sel,
  input  logic [ADC_SEL_W-1:0]  adc_sel,
  output logic                  main_stb,
  output logic                  fast_stb,
  output logic                  fast_tmr_stb,
  output logic                  slow_stb,
  output logic                  slow_tmr_stb,
  output logic                  adc_stb,
  output logic                  tick_stb,
  output logic                  store_stb,
  output logic                  over_limit
);
  localparam int TICK_W  = (TICK_RATIO  > 1) ? $clog2(TICK_RATIO)  : 1;
  localparam int STORE_W = (STORE_RATIO > 1) ? $clog2(STORE_RATIO) : 1;
  localparam int N_BUS   = 2;

  // root: enabled every cycle once out of reset
  sub_div #(.CNT_W(MAIN_CNT_W)) u_main (
    .clk(clk), .rst_n(rst_n), .parent_stb(rst_n),
    .div_m1(MAIN_CNT_W'(main_ratio(main_sel) - 1)), .stb(main_stb));

  // peripheral buses: index 0 fast, 1 slow
  logic [BUS_SEL_W-1:0] bus_sel [N_BUS];
  logic [N_BUS-1:0]     bus_stb, bus_tmr;
  assign bus_sel[0] = fast_sel;
  assign bus_sel[1] = slow_sel;

  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    bus_div u_bus (
      .clk(clk), .rst_n(rst_n), .parent_stb(main_stb),
      .sel(bus_sel[b]), .stb(bus_stb[b]), .tmr_stb(bus_tmr[b]));
  end

  assign fast_stb     = bus_stb[0];
  assign slow_stb     = bus_stb[1];
  assign fast_tmr_stb = bus_tmr[0];
  assign slow_tmr_stb = bus_tmr[1];

  sub_div #(.CNT_W(ADC_CNT_W)) u_adc (
    .clk(clk), .rst_n(rst_n), .parent_stb(fast_stb),
    .div_m1(ADC_CNT_W'(adc_ratio(adc_sel) - 1)), .stb(adc_stb));

  sub_div #(.CNT_W(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .parent_stb(main_stb),
    .div_m1(TICK_W'(TICK_RATIO - 1)), .stb(tick_stb));

  sub_div #(.CNT_W(STORE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .parent_stb(main_stb),
    .div_m1(STORE_W'(STORE_RATIO - 1)), .stb(store_stb));

  rate_guard #(.SYS_HZ(SYS_HZ), .SLOW_MAX_HZ(SLOW_MAX_HZ), .ADC_MAX_HZ(ADC_MAX_HZ)) u_guard (
    .main_sel(main_sel), .fast_sel(fast_sel), .slow_sel(slow_sel),
    .adc_sel(adc_sel), .over_limit(over_limit));

  // R8: derived strobes only inside their parent's strobe cycle
  assert_fast_in_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_stb || fast_tmr_stb) |-> main_stb);
  assert_slow_in_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_stb || slow_tmr_stb) |-> main_stb);
  assert_adc_in_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_stb |-> fast_stb);
  assert_tick_store_in_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_stb || store_stb) |-> main_stb);
  // R7: storage strobe never fires on two consecutive main strobes at /1
  assert_store_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_stb && main_sel[3] == 1'b0) |=> !store_stb);
endmodule

// File: tb/bus_strobe_gen_test.sv
module bus_strobe_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] main_sel = '0;
  logic [2:0] fast_sel = '0, slow_sel = '0;
  logic [1:0] adc_sel = '0;
  logic main_stb, fast_stb, fast_tmr_stb, slow_stb, slow_tmr_stb;
  logic adc_stb, tick_stb, store_stb, over_limit;

  int n_chk = 0, n_fail = 0, parent_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .main_sel(main_sel), .fast_sel(fast_sel),
    .slow_sel(slow_sel), .adc_sel(adc_sel), .main_stb(main_stb),
    .fast_stb(fast_stb), .fast_tmr_stb(fast_tmr_stb), .slow_stb(slow_stb),
    .slow_tmr_stb(slow_tmr_stb), .adc_stb(adc_stb), .tick_stb(tick_stb),
    .store_stb(store_stb), .over_limit(over_limit));

  function automatic int exp_main(int c);
    if (c < 8) return 1;
    case (c)
      8: return 2;   9: return 4;   10: return 8;   11: return 16;
      12: return 64; 13: return 128; 14: return 256; default: return 512;
    endcase
  endfunction

  function automatic int exp_bus(int c);
    case (c)
      4: return 2; 5: return 4; 6: return 8; 7: return 16;
      default: return 1;
    endcase
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_cfg(input int m, input int f, input int s, input int a, input int len);
    string tag [8] = '{"R2 main", "R3 fast bus", "R4 fast timer", "R3 slow bus",
                       "R4 slow timer", "R5 adc", "R6 tick", "R7 store"};
    int per [8];
    int errs [8];
    int bad_k [8];
    logic [7:0] got;
    int dm, df, ds, da;
    longint sys, lim_s, lim_a;
    bit exp_ov;
    dm = exp_main(m); df = exp_bus(f); ds = exp_bus(s); da = 2 * (a + 1);
    per[0] = dm;                            per[1] = dm * df;
    per[2] = dm * ((df == 1) ? 1 : df / 2); per[3] = dm * ds;
    per[4] = dm * ((ds == 1) ? 1 : ds / 2); per[5] = dm * df * da;
    per[6] = 8 * dm;                        per[7] = 2 * dm;
    foreach (errs[i]) begin errs[i] = 0; bad_k[i] = -1; end
    @(negedge clk);
    rst_n = 1'b0;
    main_sel = 4'(m); fast_sel = 3'(f); slow_sel = 3'(s); adc_sel = 2'(a);
    #1;
    got = {main_stb, fast_stb, fast_tmr_stb, slow_stb, slow_tmr_stb, adc_stb, tick_stb, store_stb};
    check(got == 8'h00, "R1 strobes low in reset", longint'(got), 0);
    sys = 72_000_000; lim_s = 36_000_000; lim_a = 14_000_000;
    exp_ov = (sys > lim_s * dm * ds) || (sys > lim_a * dm * df * da);
    check(over_limit == exp_ov, "R10 over_limit", longint'(over_limit), longint'(exp_ov));
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < len; k++) begin
      #1;
      got = {main_stb, fast_stb, fast_tmr_stb, slow_stb, slow_tmr_stb, adc_stb, tick_stb, store_stb};
      if (k == 0)
        check(got == 8'hFF, "R1 all strobes in first cycle", longint'(got), 255);
      for (int i = 0; i < 8; i++) begin
        if (got[7-i] != ((k % per[i]) == 0)) begin
          if (errs[i] == 0) bad_k[i] = k;
          errs[i]++;
        end
      end
      if (((fast_stb | fast_tmr_stb | slow_stb | slow_tmr_stb | tick_stb | store_stb) && !main_stb)
          || (adc_stb && !fast_stb))
        parent_err++;
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++)
      check(errs[i] == 0, $sformatf("%s cfg m=%0d f=%0d s=%0d a=%0d period %0d first bad cycle",
            tag[i], m, f, s, a, per[i]), longint'(bad_k[i]), -1);
  endtask

  // R9: fast bus /8, switched to /4 code... then /2 mid-period
  task automatic run_midchange();
    int errs = 0, bad = -1;
    bit exp;
    @(negedge clk);
    rst_n = 1'b0;
    main_sel = 4'd0; fast_sel = 3'd6; slow_sel = 3'd0; adc_sel = 2'd0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      #1;
      exp = (k == 0) || (k == 8) || (k == 10) || (k == 12) || (k == 14);
      if (fast_stb != exp) begin
        if (errs == 0) bad = k;
        errs++;
      end
      if (k == 3) fast_sel = 3'd4;  // /2 from the next wrap on
      @(negedge clk);
    end
    check(errs == 0, "R9 fast bus code change mid-period, first bad cycle", longint'(bad), -1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    for (int m = 0; m < 16; m++)
      run_cfg(m, 0, 0, 0, 16 * exp_main(m) + 1);
    for (int f = 0; f < 8; f++)
      for (int s = 0; s < 8; s++)
        for (int a = 0; a < 4; a++)
          run_cfg(0, f, s, a, 260);
    run_cfg(8, 7, 5, 2, 400);
    run_cfg(9, 6, 7, 3, 520);
    run_midchange();
    check(parent_err == 0, "R8 derived strobe outside parent strobe, count", parent_err, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule